// File: doc/BRIEF.md
# Buffered Serial Byte Transmitter

This block sends bytes out on one serial output line at 115 200 bit/s. Each frame is 8 data bits with no parity and a single stop bit. A first-in, first-out queue sits in front of the serializer. A producer can therefore hand over a burst of bytes while an earlier byte is still on the wire. The serializer drains the queue one byte after another. When a byte is waiting, its start bit follows the previous stop bit with no idle time between them.

A byte is handed over by driving its value on `wr_data` and raising `wr_en` for one clock cycle. The `busy` output reports only that the queue is full; it says nothing about line activity. The bit period is derived at elaboration time from the system clock frequency parameter.

Top module: `uart_fifo_tx`

## Requirements
- R1: Every bit on `tx` lasts exactly DIV clock cycles, where DIV = round(CLK_HZ / 115200) to the nearest integer; with CLK_HZ = 1 000 000, DIV = 9.
- R2: `tx` is 1 while idle; a frame is one low start bit, then the 8 data bits with bit 0 first and bit 7 last, then one high stop bit.
- R3: While `busy` is 0, a cycle with `wr_en` = 1 queues the value on `wr_data`, and that byte is later sent.
- R4: `busy` is 1 exactly while the queue holds DEPTH bytes, and it returns to 0 in the cycle after the serializer takes a byte out of a full queue.
- R5: A cycle with `wr_en` = 1 while `busy` is 1 has no effect: the byte is never sent and the queue contents are unchanged.
- R6: Queued bytes leave the line in the order they were written.
- R7: If the queue is not empty when a stop bit ends, the next start bit begins on the next clock cycle, so successive start bits are exactly 10 x DIV cycles apart.
- R8: A synchronous active-high `rst` empties the queue, drops any frame in progress, drives `tx` to 1 and `busy` to 0 from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle strobe that offers `wr_data` to the queue |
| wr_data | input | 8 | Byte to be queued |
| busy | output | 1 | Queue full; writes are refused while high |
| tx | output | 1 | Serial output line, idles high |

## Verification
The assertions take for granted that `rst` is driven to a known level from the very first clock edge. They also assume that `wr_en` and `wr_data` are free of unknown values while out of reset. Writes made while `busy` is high are legal stimulus, so the checker treats them as refused rather than forbidden. The bench drives every input at the falling clock edge and keeps `rst` high at time zero. It also pushes writes into a full queue on purpose, so the refusal path is actually exercised.

// File: rtl/uft_pkg.sv
package uft_pkg;

  localparam int unsigned LINE_BAUD  = 115200;
  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned FRAME_BITS = DATA_BITS + 2;

  typedef enum logic {
    SER_IDLE = 1'b0,
    SER_SEND = 1'b1
  } ser_state_e;

  // clock cycles per bit, rounded to nearest, never below one
  function automatic int unsigned calc_div(input int unsigned clk_hz,
                                           input int unsigned baud);
    int unsigned q;
    q = (clk_hz + baud / 2) / baud;
    return (q == 0) ? 1 : q;
  endfunction

  // whole frame, bit 0 leaves first: start(0), data LSB first, stop(1)
  function automatic logic [FRAME_BITS-1:0] make_frame(
      input logic [DATA_BITS-1:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  function automatic int unsigned ptr_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/uft_fifo.sv
module uft_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = uft_pkg::ptr_width(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  rd_data,
  output logic          empty,
  output logic          full,
  output logic          push_ok,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop && !empty;
  assign rd_data = mem[rd_ptr];

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/uft_baud_gen.sv
module uft_baud_gen #(
  parameter int unsigned DIV = 434,
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/uft_serializer.sv
module uft_serializer
  import uft_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 have_data,
  input  logic [DATA_BITS-1:0] data,
  output logic                 take,
  output logic                 tx,
  output logic                 active,
  output logic                 frame_start,
  output logic                 frame_end
);

  localparam int unsigned IW = $clog2(FRAME_BITS);

  ser_state_e            state;
  logic [FRAME_BITS-1:0] shreg;
  logic [IW-1:0]         bit_idx;

  assign active      = (state == SER_SEND);
  assign frame_end   = active && tick && (bit_idx == IW'(FRAME_BITS - 1));
  assign frame_start = have_data && (!active || frame_end);
  assign take        = frame_start;
  assign tx          = shreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SER_IDLE;
      shreg   <= '1;
      bit_idx <= '0;
    end else if (frame_start) begin
      state   <= SER_SEND;
      shreg   <= make_frame(data);
      bit_idx <= '0;
    end else if (frame_end) begin
      state   <= SER_IDLE;
      shreg   <= '1;
      bit_idx <= '0;
    end else if (active && tick) begin
      shreg   <= {1'b1, shreg[FRAME_BITS-1:1]};
      bit_idx <= bit_idx + 1'b1;
    end
  end

endmodule

// File: rtl/uart_fifo_tx.sv
module uart_fifo_tx #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned DEPTH  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       busy,
  output logic       tx
);

  localparam int unsigned DIV_CYC = uft_pkg::calc_div(CLK_HZ, uft_pkg::LINE_BAUD);
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1);

  logic             fifo_push;
  logic             fifo_pop;
  logic             fifo_empty;
  logic             fifo_full;
  logic [7:0]       fifo_head;
  logic [CNT_W-1:0] fifo_count;
  logic             baud_tick;
  logic             ser_active;
  logic             frame_start;
  logic             frame_end;

  uft_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push_req  (wr_en),
    .push_data (wr_data),
    .pop       (fifo_pop),
    .rd_data   (fifo_head),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .push_ok   (fifo_push),
    .count     (fifo_count)
  );

  uft_baud_gen #(.DIV(DIV_CYC)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .run  (ser_active),
    .tick (baud_tick)
  );

  uft_serializer u_ser (
    .clk         (clk),
    .rst         (rst),
    .tick        (baud_tick),
    .have_data   (!fifo_empty),
    .data        (fifo_head),
    .take        (fifo_pop),
    .tx          (tx),
    .active      (ser_active),
    .frame_start (frame_start),
    .frame_end   (frame_end)
  );

  assign busy = fifo_full;

endmodule

// File: rtl/uart_fifo_tx_chk.sv
module uart_fifo_tx_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DIV   = 434,
  parameter int unsigned CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          busy,
  input logic          tx,
  input logic          fifo_push,
  input logic          fifo_pop,
  input logic [CW-1:0] fifo_count,
  input logic          baud_tick,
  input logic          ser_active,
  input logic          frame_start,
  input logic          frame_end
);

  int unsigned gap;

  always_ff @(posedge clk) begin
    if (rst || frame_start || baud_tick) gap <= 0;
    else                                 gap <= gap + 1;
  end

  // R1: ticks are DIV cycles apart, counted from the frame start
  a_r1_bit_period: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> gap == DIV - 1);

  // R2: start bit is low on the line after a frame starts
  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !tx);

  // R2: the line is high whenever no frame is in progress
  a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
    !ser_active |-> tx);

  // R4: a push into a queue with no pop raises the count by one
  a_r4_count_up: assert property (@(posedge clk) disable iff (rst)
    fifo_push && !fifo_pop |=> fifo_count == $past(fifo_count) + 1'b1);

  // R4: taking from a full queue clears busy on the next cycle
  a_r4_busy_release: assert property (@(posedge clk) disable iff (rst)
    busy && fifo_pop |=> !busy);

  // R5: a write offered while busy is refused
  a_r5_refuse_when_busy: assert property (@(posedge clk) disable iff (rst)
    wr_en && busy |-> !fifo_push);

  // R7: waiting data is taken in the very cycle a stop bit ends
  a_r7_no_gap: assert property (@(posedge clk) disable iff (rst)
    frame_end && fifo_count != '0 |-> fifo_pop);

  // R8: reset leaves an idle line, an empty queue and busy low
  a_r8_reset_state: assert property (@(posedge clk)
    rst |=> tx && !busy && fifo_count == '0);

endmodule

bind uart_fifo_tx uart_fifo_tx_chk #(.DEPTH(DEPTH), .DIV(DIV_CYC), .CW(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .busy        (busy),
  .tx          (tx),
  .fifo_push   (fifo_push),
  .fifo_pop    (fifo_pop),
  .fifo_count  (fifo_count),
  .baud_tick   (baud_tick),
  .ser_active  (ser_active),
  .frame_start (frame_start),
  .frame_end   (frame_end)
);

// File: tb/uart_fifo_tx_tb.sv
`timescale 1ns/1ps
module uart_fifo_tx_tb;

  localparam int unsigned CLK_HZ = 1_000_000;
  localparam int unsigned DEPTH  = 4;
  localparam int DIV = $rtoi(real'(CLK_HZ) / 115200.0 + 0.5);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       busy;
  logic       tx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int   mon_idx = 0;
  logic [7:0] mon_byte [0:1023];
  int   mon_start [0:1023];
  logic mon_sb_ok [0:1023];

  uart_fifo_tx #(.CLK_HZ(CLK_HZ), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .busy(busy), .tx(tx)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // line receiver: samples each bit in its middle
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && tx === 1'b0) begin
        logic [7:0] d;
        logic       s0;
        int         st;
        st = cyc;
        repeat (DIV / 2) @(negedge clk);
        s0 = tx;
        for (int i = 0; i < 8; i++) begin
          repeat (DIV) @(negedge clk);
          d[i] = tx;
        end
        repeat (DIV) @(negedge clk);
        mon_byte[mon_idx]  = d;
        mon_start[mon_idx] = st;
        mon_sb_ok[mon_idx] = (s0 === 1'b0) && (tx === 1'b1);
        mon_idx = mon_idx + 1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  initial begin
    int base;
    int low_len;
    logic [7:0] burst [5];

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(tx === 1'b1, "R8", "tx after reset", int'(tx), 1);
    check(busy === 1'b0, "R8", "busy after reset", int'(busy), 0);

    // R1: start bit length, then bit 0 (a one) follows
    base = mon_idx;
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0;
    while (tx !== 1'b0) @(negedge clk);
    low_len = 0;
    while (tx === 1'b0 && low_len < 100) begin
      low_len++;
      @(negedge clk);
    end
    check(low_len == DIV, "R1", "start bit length", low_len, DIV);
    wait (mon_idx == base + 1);
    check(mon_byte[base] == 8'h01 && mon_sb_ok[base], "R2", "frame of 0x01",
          int'(mon_byte[base]), 1);

    // R3 R2: every byte value, one at a time
    for (int v = 0; v < 256; v++) begin
      base = mon_idx;
      write_byte(8'(v));
      wait (mon_idx == base + 1);
      check(mon_byte[base] == 8'(v) && mon_sb_ok[base], "R3",
            "single byte sweep", int'(mon_byte[base]), v);
    end
    repeat (2 * DIV) @(negedge clk);

    // R4 R5 R6 R7: burst into the queue
    burst[0] = 8'hA5; burst[1] = 8'h3C; burst[2] = 8'h81;
    burst[3] = 8'h7E; burst[4] = 8'h0F;
    base = mon_idx;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      wr_en = 1'b1; wr_data = burst[i];
      @(negedge clk);
      if (i == 3) check(busy === 1'b0, "R4", "busy before queue full", int'(busy), 0);
    end
    wr_en = 1'b0;
    check(busy === 1'b1, "R4", "busy with full queue", int'(busy), 1);
    // R5: offered while full, must never appear
    wr_en = 1'b1; wr_data = 8'hEE;
    @(negedge clk);
    wr_en = 1'b0;
    check(busy === 1'b1, "R5", "busy after refused write", int'(busy), 1);
    // busy drops the cycle after the first frame ends and the next is taken
    while (busy === 1'b1) @(negedge clk);
    check(mon_idx == base + 1, "R4", "busy release at first frame end",
          mon_idx - base, 1);
    wait (mon_idx == base + 5);
    for (int i = 0; i < 5; i++)
      check(mon_byte[base+i] == burst[i] && mon_sb_ok[base+i], "R6",
            "burst order", int'(mon_byte[base+i]), int'(burst[i]));
    for (int i = 1; i < 5; i++)
      check(mon_start[base+i] - mon_start[base+i-1] == 10 * DIV, "R7",
            "start spacing", mon_start[base+i] - mon_start[base+i-1], 10 * DIV);
    repeat (20 * DIV) @(negedge clk);
    check(mon_idx == base + 5, "R5", "no extra frame", mon_idx - base, 5);
    check(tx === 1'b1 && busy === 1'b0, "R5", "line idle after drain", int'(tx), 1);

    // R8: reset in the middle of a frame with bytes waiting
    write_byte(8'h00);
    write_byte(8'h11);
    write_byte(8'h22);
    repeat (3 * DIV) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(tx === 1'b1, "R8", "tx right after mid-frame reset", int'(tx), 1);
    check(busy === 1'b0, "R8", "busy right after mid-frame reset", int'(busy), 0);
    low_len = 0;
    for (int i = 0; i < 30 * DIV; i++) begin
      @(negedge clk);
      if (tx !== 1'b1) low_len++;
    end
    check(low_len == 0, "R8", "queue emptied by reset", low_len, 0);

    finish_run();
  end

endmodule